// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block produces Ethernet frames for hardware loopback tests. Software fills a small set of 32-bit registers with a frame count, a destination and a source MAC address, a length limit and two mode bits. It then writes a start command. The block streams the frames one byte per cycle on a valid/ready interface and flags the first and last byte of each frame. Every frame carries the two addresses and a length field, then a payload, then a 4-byte frame check sequence.

The payload is either a counting pattern or bytes drawn from an internal 32-bit LFSR. Frame length is either the programmed limit or a random draw from the same LFSR, bounded below by the minimum Ethernet frame. A stop command ends the run at the next frame boundary. A readable counter reports how many frames have left the block, so a monitor on the far side of the loop can compare its own count against it.

Top module: `eth_testgen`

## Requirements
- R1: After synchronous reset every register reads zero, `tx_valid` is low and the sent counter is zero.
- R2: Byte offsets: 0x00 frame count, 0x04 random-length bit (bit 0), 0x08 random-payload bit (bit 0), 0x0C start command, 0x10 stop command, 0x14/0x18 source MAC low 32 / high 16 bits, 0x1C/0x20 destination MAC low 32 / high 16 bits, 0x24 sent counter (read-only), 0x34 length limit (16 bits). The MAC high registers read back only bits 15:0. The mode registers read back only bit 0. The command offsets, the unmapped offsets and the upper bits read zero. Writes to 0x24 have no effect. Read data appears the cycle after `reg_rd`.
- R3: Writing a value with bit 0 set to 0x0C while idle sends exactly the programmed number of frames, back to back, then goes idle. A count of zero sends nothing. A start written while frames are going out is ignored.
- R4: Frame bytes 0-5 are the destination MAC, most significant byte first. Bytes 6-11 are the source MAC, in the same order. Bytes 12-13 hold the frame length minus 18, high byte first.
- R5: In fixed-length mode every frame is L bytes long, counting the check sequence, where L is the length limit clamped to the range 64..1518.
- R6: In random-length mode each frame length is the LFSR's low 11 bits clamped to 64..L. The LFSR steps right-shift Galois style: s = (s >> 1) XOR (s[0] ? 0xA3000000 : 0). It is reseeded to 0x1D872B41 on every accepted start. One draw and one step are taken per frame before its first byte.
- R7: In incrementing payload mode, payload byte k (counted from byte 14) equals k mod 256.
- R8: In random payload mode each payload byte equals the LFSR's low 8 bits, and the LFSR steps once per payload byte after it is accepted.
- R9: The last four bytes are the reflected CRC-32 of all prior bytes, computed with polynomial 0xEDB88320, initial value 0xFFFFFFFF and the result inverted. They are sent least significant byte first.
- R10: A stop command written to 0x10 lets the current frame finish and sends no further frame. This includes a stop taken in the cycle of a frame's last byte. A stop while idle has no lasting effect.
- R11: The sent counter at 0x24 is cleared by an accepted start and increments once per accepted last byte.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold their values.
- R13: `tx_sop` marks byte 0 and `tx_eop` marks the last byte of each frame. A frame that follows another starts in the cycle after the previous last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte is valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_sop | output | 1 | First byte of a frame |
| tx_eop | output | 1 | Last byte of a frame |

## Verification
Two events can meet in one cycle. A stop command can land in the very cycle that the last byte of a frame is accepted. A start command can arrive while a run is still streaming. The bench holds ready high, so the acceptance cycle of each byte is known. It then places the stop write exactly on the 64th byte of the first frame and places a second start in the middle of a run. The scoreboard judges the outcome from the frames that appear on the stream and from the sent counter read back afterwards: one frame in the first case, and an undisturbed run with an uncleared count in the second.

// File: rtl/eth_testgen_pkg.sv
package eth_testgen_pkg;

    localparam int REG_W     = 32;
    localparam int LEN_W     = 11;
    localparam int MIN_FRAME = 64;
    localparam int MAX_FRAME = 1518;
    localparam int MAC_BYTES = 6;
    localparam int HDR_BYTES = 14;
    localparam int FCS_BYTES = 4;

    localparam logic [31:0] LFSR_SEED = 32'h1D87_2B41;
    localparam logic [31:0] LFSR_MASK = 32'hA300_0000;
    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;

    localparam logic [7:0] OFS_FRAMES  = 8'h00;
    localparam logic [7:0] OFS_RLEN    = 8'h04;
    localparam logic [7:0] OFS_RPAY    = 8'h08;
    localparam logic [7:0] OFS_GO      = 8'h0C;
    localparam logic [7:0] OFS_HALT    = 8'h10;
    localparam logic [7:0] OFS_SRC_LO  = 8'h14;
    localparam logic [7:0] OFS_SRC_HI  = 8'h18;
    localparam logic [7:0] OFS_DST_LO  = 8'h1C;
    localparam logic [7:0] OFS_DST_HI  = 8'h20;
    localparam logic [7:0] OFS_SENT    = 8'h24;
    localparam logic [7:0] OFS_LIMIT   = 8'h34;

    typedef enum logic {GEN_IDLE, GEN_SEND} gen_state_e;

    typedef struct packed {
        logic [31:0] frames;
        logic        rand_len;
        logic        rand_pay;
        logic [47:0] src_mac;
        logic [47:0] dst_mac;
        logic [15:0] len_limit;
    } gen_cfg_t;

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : 32'h0);
    endfunction

    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [LEN_W-1:0] clamp_limit(input logic [15:0] v);
        if (v < 16'(MIN_FRAME)) return LEN_W'(MIN_FRAME);
        if (v > 16'(MAX_FRAME)) return LEN_W'(MAX_FRAME);
        return v[LEN_W-1:0];
    endfunction

    function automatic logic [LEN_W-1:0] pick_len(input logic rnd, input logic [31:0] s,
                                                  input logic [LEN_W-1:0] lim);
        logic [LEN_W-1:0] c;
        c = s[LEN_W-1:0];
        if (!rnd) return lim;
        if (c < LEN_W'(MIN_FRAME)) return LEN_W'(MIN_FRAME);
        if (c > lim) return lim;
        return c;
    endfunction

    function automatic logic [7:0] mac_byte(input logic [47:0] m, input logic [2:0] i);
        return m[8*(5-int'(i)) +: 8];
    endfunction

endpackage

// File: rtl/eth_testgen_regs.sv
module eth_testgen_regs
    import eth_testgen_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [31:0]       sent_count,
    output gen_cfg_t          cfg,
    output logic              go,
    output logic              halt
);

    logic [31:0] frames_q, src_lo_q, dst_lo_q;
    logic [15:0] src_hi_q, dst_hi_q, limit_q;
    logic        rlen_q, rpay_q;
    logic [REG_W-1:0] rd_mux;

    assign go   = reg_wr && (reg_addr == ADDR_W'(OFS_GO))   && reg_wdata[0];
    assign halt = reg_wr && (reg_addr == ADDR_W'(OFS_HALT)) && reg_wdata[0];

    assign cfg.frames    = frames_q;
    assign cfg.rand_len  = rlen_q;
    assign cfg.rand_pay  = rpay_q;
    assign cfg.src_mac   = {src_hi_q, src_lo_q};
    assign cfg.dst_mac   = {dst_hi_q, dst_lo_q};
    assign cfg.len_limit = limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frames_q <= '0;
            src_lo_q <= '0;
            dst_lo_q <= '0;
            src_hi_q <= '0;
            dst_hi_q <= '0;
            limit_q  <= '0;
            rlen_q   <= 1'b0;
            rpay_q   <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(OFS_FRAMES): frames_q <= reg_wdata;
                ADDR_W'(OFS_RLEN):   rlen_q   <= reg_wdata[0];
                ADDR_W'(OFS_RPAY):   rpay_q   <= reg_wdata[0];
                ADDR_W'(OFS_SRC_LO): src_lo_q <= reg_wdata;
                ADDR_W'(OFS_SRC_HI): src_hi_q <= reg_wdata[15:0];
                ADDR_W'(OFS_DST_LO): dst_lo_q <= reg_wdata;
                ADDR_W'(OFS_DST_HI): dst_hi_q <= reg_wdata[15:0];
                ADDR_W'(OFS_LIMIT):  limit_q  <= reg_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(OFS_FRAMES): rd_mux = frames_q;
            ADDR_W'(OFS_RLEN):   rd_mux = {31'h0, rlen_q};
            ADDR_W'(OFS_RPAY):   rd_mux = {31'h0, rpay_q};
            ADDR_W'(OFS_SRC_LO): rd_mux = src_lo_q;
            ADDR_W'(OFS_SRC_HI): rd_mux = {16'h0, src_hi_q};
            ADDR_W'(OFS_DST_LO): rd_mux = dst_lo_q;
            ADDR_W'(OFS_DST_HI): rd_mux = {16'h0, dst_hi_q};
            ADDR_W'(OFS_SENT):   rd_mux = sent_count;
            ADDR_W'(OFS_LIMIT):  rd_mux = {16'h0, limit_q};
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/eth_testgen_crc.sv
module eth_testgen_crc
    import eth_testgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        first,
    input  logic [7:0]  data,
    output logic [31:0] fcs
);

    logic [31:0] crc_q;
    logic [31:0] crc_base;

    assign crc_base = first ? CRC_INIT : crc_q;
    assign fcs      = ~crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_INIT;
        end else if (take) begin
            crc_q <= crc32_byte(crc_base, data);
        end
    end

endmodule

// File: rtl/eth_testgen_seq.sv
module eth_testgen_seq
    import eth_testgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  gen_cfg_t    cfg,
    input  logic        go,
    input  logic        halt,
    input  logic        tx_ready,
    input  logic [31:0] fcs,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_sop,
    output logic        tx_eop,
    output logic        crc_take,
    output logic        crc_first,
    output logic [31:0] sent_count
);

    gen_state_e       state;
    logic [LEN_W-1:0] idx, flen, lim;
    logic [LEN_W-1:0] body_end, plen, pay_idx, start_lim;
    logic [31:0]      left, lfsr;
    logic             stop_pend, lat_rl, lat_rp;
    logic             hs, in_body, in_payload, last_byte, finish;
    logic [15:0]      plen16;
    logic [1:0]       fcs_sel;

    assign tx_valid   = (state == GEN_SEND);
    assign hs         = tx_valid && tx_ready;
    assign body_end   = flen - LEN_W'(FCS_BYTES);
    assign plen       = flen - LEN_W'(HDR_BYTES + FCS_BYTES);
    assign plen16     = 16'(plen);
    assign pay_idx    = idx - LEN_W'(HDR_BYTES);
    assign fcs_sel    = 2'(idx - body_end);
    assign in_body    = idx < body_end;
    assign in_payload = in_body && (idx >= LEN_W'(HDR_BYTES));
    assign last_byte  = idx == (flen - LEN_W'(1));
    assign tx_sop     = tx_valid && (idx == '0);
    assign tx_eop     = tx_valid && last_byte;
    assign crc_take   = hs && in_body;
    assign crc_first  = (idx == '0);
    assign finish     = (left == 32'd1) || stop_pend || halt;
    assign start_lim  = clamp_limit(cfg.len_limit);

    always_comb begin
        if (idx < LEN_W'(MAC_BYTES)) begin
            tx_data = mac_byte(cfg.dst_mac, 3'(idx));
        end else if (idx < LEN_W'(2*MAC_BYTES)) begin
            tx_data = mac_byte(cfg.src_mac, 3'(idx - LEN_W'(MAC_BYTES)));
        end else if (idx == LEN_W'(2*MAC_BYTES)) begin
            tx_data = plen16[15:8];
        end else if (idx == LEN_W'(2*MAC_BYTES + 1)) begin
            tx_data = plen16[7:0];
        end else if (in_body) begin
            tx_data = lat_rp ? lfsr[7:0] : pay_idx[7:0];
        end else begin
            tx_data = fcs[8*fcs_sel +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= GEN_IDLE;
            idx        <= '0;
            flen       <= LEN_W'(MIN_FRAME);
            lim        <= LEN_W'(MIN_FRAME);
            left       <= '0;
            lfsr       <= LFSR_SEED;
            stop_pend  <= 1'b0;
            lat_rl     <= 1'b0;
            lat_rp     <= 1'b0;
            sent_count <= '0;
        end else begin
            case (state)
                GEN_IDLE: begin
                    if (go) begin
                        sent_count <= '0;
                        stop_pend  <= 1'b0;
                        lat_rl     <= cfg.rand_len;
                        lat_rp     <= cfg.rand_pay;
                        lim        <= start_lim;
                        lfsr       <= cfg.rand_len ? lfsr_step(LFSR_SEED) : LFSR_SEED;
                        flen       <= pick_len(cfg.rand_len, LFSR_SEED, start_lim);
                        left       <= cfg.frames;
                        idx        <= '0;
                        if (cfg.frames != 32'd0) state <= GEN_SEND;
                    end
                end
                GEN_SEND: begin
                    if (halt) stop_pend <= 1'b1;
                    if (hs) begin
                        if (last_byte) begin
                            sent_count <= sent_count + 32'd1;
                            idx        <= '0;
                            if (finish) begin
                                state     <= GEN_IDLE;
                                stop_pend <= 1'b0;
                            end else begin
                                left <= left - 32'd1;
                                flen <= pick_len(lat_rl, lfsr, lim);
                                if (lat_rl) lfsr <= lfsr_step(lfsr);
                            end
                        end else begin
                            idx <= idx + LEN_W'(1);
                            if (lat_rp && in_payload) lfsr <= lfsr_step(lfsr);
                        end
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eth_testgen.sv
module eth_testgen
    import eth_testgen_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_sop,
    output logic              tx_eop
);

    gen_cfg_t    cfg;
    logic        go, halt, crc_take, crc_first;
    logic [31:0] fcs, sent_count;

    eth_testgen_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .sent_count (sent_count),
        .cfg        (cfg),
        .go         (go),
        .halt       (halt)
    );

    eth_testgen_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .go         (go),
        .halt       (halt),
        .tx_ready   (tx_ready),
        .fcs        (fcs),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_sop     (tx_sop),
        .tx_eop     (tx_eop),
        .crc_take   (crc_take),
        .crc_first  (crc_first),
        .sent_count (sent_count)
    );

    eth_testgen_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .take  (crc_take),
        .first (crc_first),
        .data  (tx_data),
        .fcs   (fcs)
    );

endmodule

// File: rtl/eth_testgen_sva.sv
module eth_testgen_sva (
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_sop,
    input logic        tx_eop,
    input logic [7:0]  tx_data,
    input logic [31:0] sent_count
);

    logic [15:0] run_len;
    logic        accept;

    assign accept = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (accept) begin
            run_len <= tx_eop ? 16'd0 : run_len + 16'd1;
        end
    end

    // R1: leaving reset, nothing is offered and the counter is clear
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tx_valid && sent_count == 32'd0));

    // R12: an offered byte is held until taken
    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

    // R13: a frame never starts and ends on one byte
    assert_sop_not_eop_R13: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_sop) |-> !tx_eop);

    // R13: after a last byte, the next offered byte opens a frame
    assert_next_sop_R13: assert property (@(posedge clk) disable iff (rst)
        (accept && tx_eop) |=> (!tx_valid || tx_sop));

    // R5: frame lengths stay within 64..1518 bytes
    assert_len_window_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && tx_eop) |-> (run_len >= 16'd63 && run_len <= 16'd1517));

    // R11: counter steps once per finished frame
    assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && tx_eop) |=> (sent_count == $past(sent_count) + 32'd1));

endmodule

bind eth_testgen eth_testgen_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_sop     (tx_sop),
    .tx_eop     (tx_eop),
    .tx_data    (tx_data),
    .sent_count (sent_count)
);

// File: tb/eth_testgen_test.sv
module eth_testgen_test;

    localparam logic [31:0] SEED = 32'h1D87_2B41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_sop, tx_eop;
    logic        tx_ready = 1'b1;

    always #5 clk = ~clk;

    eth_testgen uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    int          nbytes = 0;
    int          cyc = 0;
    logic        fast_ready = 1'b1;
    logic [9:0]  expq[$];
    logic [9:0]  mon_exp;
    logic [47:0] dst = 48'h0A1B_2C3D_4E5F;
    logic [47:0] src = 48'h6655_4433_2211;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 tx_ready = fast_ready ? 1'b1 : ((cyc % 3) != 1);
    end

    // scoreboard monitor: compares every accepted byte with the queue
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            nbytes++;
            if (expq.size() == 0) begin
                check(1'b0, "R3 byte beyond the expected frames", tx_data, 0);
            end else begin
                mon_exp = expq.pop_front();
                check({tx_sop, tx_eop, tx_data} == mon_exp,
                      "R4 R5 R6 R7 R8 R9 R12 R13 stream byte {sop,eop,data}",
                      {tx_sop, tx_eop, tx_data}, mon_exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk);
        #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk);
        #1 reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        #1 reg_rd = 1'b0; d = reg_rdata;
    endtask

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'hA300_0000) : (s >> 1);
    endfunction

    function automatic logic [31:0] m_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 32'hEDB8_8320;
            else r = r >> 1;
        end
        return r;
    endfunction

    function automatic int m_limit(input int v);
        return (v < 64) ? 64 : ((v > 1518) ? 1518 : v);
    endfunction

    // pushes the frames a run of n frames must produce
    task automatic model(input int n, input bit rl, input bit rp, input int limit);
        logic [31:0] lf;
        logic [31:0] crc;
        logic [7:0]  b;
        int          len;
        int          mx;
        lf = SEED;
        mx = m_limit(limit);
        for (int f = 0; f < n; f++) begin
            if (rl) begin
                len = int'(lf[10:0]);
                if (len < 64) len = 64;
                if (len > mx) len = mx;
                lf = m_step(lf);
            end else begin
                len = mx;
            end
            crc = 32'hFFFF_FFFF;
            for (int i = 0; i < len; i++) begin
                if (i < 6)            b = dst[8*(5-i) +: 8];
                else if (i < 12)      b = src[8*(11-i) +: 8];
                else if (i == 12)     b = 8'((len - 18) >> 8);
                else if (i == 13)     b = 8'(len - 18);
                else if (i < len - 4) begin
                    if (rp) begin b = lf[7:0]; lf = m_step(lf); end
                    else b = 8'(i - 14);
                end else begin
                    b = 8'((~crc) >> (8*(i - (len - 4))));
                end
                if (i < len - 4) crc = m_crc(crc, b);
                expq.push_back({(i == 0), (i == len - 1), b});
            end
        end
    endtask

    task automatic setup(input int n, input bit rl, input bit rp, input int limit);
        wr(8'h00, n);
        wr(8'h04, {31'h0, rl});
        wr(8'h08, {31'h0, rp});
        wr(8'h34, limit);
    endtask

    task automatic drain(input string tag);
        int w;
        w = 0;
        while (expq.size() != 0 && w < 30000) begin
            @(posedge clk);
            w++;
        end
        repeat (30) @(posedge clk);
        check(expq.size() == 0, {tag, " all expected bytes produced"}, expq.size(), 0);
    endtask

    task automatic expect_sent(input string tag, input int exp);
        logic [31:0] v;
        rd(8'h24, v);
        check(v == 32'(exp), {tag, " sent counter"}, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          base;
        logic [7:0]  ofs[11];
        ofs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h34};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
        for (int k = 0; k < 11; k++) begin
            rd(ofs[k], v);
            check(v == 32'h0, "R1 register zero after reset", v, 0);
        end

        // R2: register access rules
        wr(8'h00, 32'h1234_5678); rd(8'h00, v);
        check(v == 32'h1234_5678, "R2 frame count readback", v, 32'h1234_5678);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v);
        check(v == 32'h1, "R2 random-length bit only", v, 1);
        wr(8'h18, 32'hFFFF_6655); rd(8'h18, v);
        check(v == 32'h0000_6655, "R2 source MAC high half", v, 32'h6655);
        wr(8'h14, 32'h4433_2211);
        wr(8'h20, 32'hDEAD_0A1B); rd(8'h20, v);
        check(v == 32'h0000_0A1B, "R2 destination MAC high half", v, 32'h0A1B);
        wr(8'h1C, 32'h2C3D_4E5F); rd(8'h1C, v);
        check(v == 32'h2C3D_4E5F, "R2 destination MAC low", v, 32'h2C3D4E5F);
        wr(8'h34, 32'hABCD_0123); rd(8'h34, v);
        check(v == 32'h0000_0123, "R2 length limit field", v, 32'h123);
        wr(8'h24, 32'h0000_0055); rd(8'h24, v);
        check(v == 32'h0, "R2 write to sent counter ignored", v, 0);
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h0); rd(8'h0C, v);
        check(v == 32'h0, "R2 start offset reads zero", v, 0);
        rd(8'h40, v);
        check(v == 32'h0, "R2 unmapped offset reads zero", v, 0);
        check(tx_valid == 1'b0, "R3 start with bit 0 clear does nothing", tx_valid, 0);

        // R3 R4 R5 R7 R9 R11: fixed length, counting payload
        setup(3, 1'b0, 1'b0, 80);
        model(3, 1'b0, 1'b0, 80);
        wr(8'h0C, 32'h1);
        drain("R3 fixed run");
        expect_sent("R11 after three frames", 3);

        // R3 R11: zero frames
        base = nbytes;
        setup(0, 1'b0, 1'b0, 80);
        wr(8'h0C, 32'h1);
        repeat (40) @(posedge clk);
        check(nbytes == base, "R3 zero count sends nothing", nbytes - base, 0);
        expect_sent("R11 cleared by start", 0);

        // R5: clamping of the limit
        setup(1, 1'b0, 1'b0, 10);
        model(1, 1'b0, 1'b0, 10);
        wr(8'h0C, 32'h1);
        drain("R5 short limit");
        setup(1, 1'b0, 1'b1, 2000);
        model(1, 1'b0, 1'b1, 2000);
        wr(8'h0C, 32'h1);
        drain("R5 R8 long limit");

        // R6 R8 R12: random length and payload under back-pressure
        fast_ready = 1'b0;
        setup(4, 1'b1, 1'b1, 300);
        model(4, 1'b1, 1'b1, 300);
        wr(8'h0C, 32'h1);
        drain("R6 R8 R12 random run");
        expect_sent("R11 random run", 4);
        setup(3, 1'b1, 1'b0, 700);
        model(3, 1'b1, 1'b0, 700);
        wr(8'h0C, 32'h1);
        drain("R6 R7 random length counting payload");
        fast_ready = 1'b1;
        repeat (2) @(posedge clk);

        // R10: stop in the middle of the second frame
        setup(5, 1'b0, 1'b0, 64);
        model(2, 1'b0, 1'b0, 64);
        base = nbytes;
        wr(8'h0C, 32'h1);
        while (nbytes < base + 70) @(posedge clk);
        wr(8'h10, 32'h1);
        drain("R10 stop mid frame");
        expect_sent("R10 R11 stop mid frame", 2);

        // R3: start while busy is ignored
        setup(2, 1'b0, 1'b0, 100);
        model(2, 1'b0, 1'b0, 100);
        base = nbytes;
        wr(8'h0C, 32'h1);
        while (nbytes < base + 130) @(posedge clk);
        wr(8'h0C, 32'h1);
        drain("R3 restart while busy");
        expect_sent("R3 R11 restart ignored", 2);

        // R10: stop taken in the cycle of the first frame's last byte
        setup(3, 1'b0, 1'b0, 64);
        model(1, 1'b0, 1'b0, 64);
        wr(8'h0C, 32'h1);
        repeat (62) @(posedge clk);
        wr(8'h10, 32'h1);
        drain("R10 stop on last byte");
        expect_sent("R10 stop on last byte", 1);

        // R10: stop while idle leaves no trace
        wr(8'h10, 32'h1);
        setup(1, 1'b0, 1'b0, 64);
        model(1, 1'b0, 1'b0, 64);
        wr(8'h0C, 32'h1);
        drain("R10 idle stop");
        expect_sent("R10 idle stop", 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule